// File: doc/BRIEF.md
# Write-Through Snoopy Invalidation Controller

This block keeps a small direct-mapped write-through cache coherent with its peers on a shared snooping bus. Each line holds one presence bit, an address tag and one data word. A processor read that finds its line present and matching is answered in the same cycle without touching the bus. A read that misses raises a bus read, waits for the grant, and fills the line from the returned word. Every processor write goes out on the bus, whether or not the line is held. A write never changes which lines are present. A write to a held line also refreshes the cached word. Main memory is always current, so the block never supplies data to anyone.

The block watches bus writes issued by other caches. When one carries the full address of a line it holds, that line is dropped. Transactions tagged with the block's own source number are ignored, and so are snooped reads. Any number of caches may hold the same address at once.

The processor side uses a valid/ready handshake. The requester raises `cpu_valid` and holds the command, address and write data stable until it sees `cpu_ready` high at a clock edge, which completes the request in that cycle. Read data on `cpu_rdata` is good in the completing cycle only. The bus side is a plain request/grant pair. `bus_req` stays high while a request needs the bus. A grant completes the transaction in the cycle where it is seen together with `bus_req`.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is absent: with no request `cpu_ready` and `bus_req` are low, and the first read of any address raises `bus_req`.
- R2: A read miss raises `bus_req` with `bus_we` = 0 (0 = read, 1 = write) and `bus_addr` = `cpu_addr`, keeps `cpu_ready` low until `bus_gnt`, and completes in the grant cycle with `cpu_rdata` = `bus_rdata`. After that the line is present.
- R3: A read of a present line with a matching tag completes in the same cycle with the stored word and leaves `bus_req` low.
- R4: Every write raises `bus_req` with `bus_we` = 1, the request's address and data, and completes in the grant cycle. It never changes line presence, so a write to an absent address leaves a later read of it missing.
- R5: A write to a present line replaces the stored word in its grant cycle, and a later read hit returns the new word.
- R6: A snooped write from another source whose full address matches a present line makes that line absent, and the next read of it misses.
- R7: A snooped foreign write to the same line index with a different tag leaves the held line present.
- R8: A snooped transaction whose `snp_src` equals `my_id` changes no line.
- R9: A snooped read (`snp_we` = 0) changes no line.
- R10: If a line-dropping snoop targets the line index of the pending processor request, the snoop wins. In that cycle `cpu_ready` and `bus_req` are low, and the request is then served as a miss.
- R11: The line index is `addr[IDX_W-1:0]` and the tag is the rest of the address. A miss to an index replaces the tag held there, so the address that was evicted misses again.
- R12: Lines at different indices are held and hit independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | ID_W | Source number of this cache on the bus |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, good when a read completes |
| bus_req | output | 1 | Bus wanted this cycle |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_we | output | 1 | Bus command: 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Memory data for a granted bus read |
| snp_valid | input | 1 | A bus transaction is visible to snoop |
| snp_we | input | 1 | Snooped command: 1 = write |
| snp_src | input | ID_W | Source number of the snooped transaction |
| snp_addr | input | ADDR_W | Snooped address |

## Verification
The assertions assume that the arbiter only grants a requester that is asking, and that the processor holds its request stable until completion. They also assume that a snooped write from another cache is never granted in the same cycle as this cache's own transaction. The bench drives the grant only while `bus_req` is high and changes the request only after a completing edge. It presents foreign snoops only when the processor is idle, with one exception: the deliberate same-index collision, where `bus_req` is low, so no grant can coincide with the snoop.

// File: rtl/wtsc_pkg.sv
`timescale 1ns/1ps
package wtsc_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } bus_op_e;
endpackage

// File: rtl/wtsc_line_array.sv
`timescale 1ns/1ps
module wtsc_line_array #(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fill_en,
  input  logic [IDX_W-1:0]              fill_idx,
  input  logic [TAG_W-1:0]              fill_tag,
  input  logic [DATA_W-1:0]             fill_data,
  input  logic                          upd_en,
  input  logic [IDX_W-1:0]              upd_idx,
  input  logic [DATA_W-1:0]             upd_data,
  input  logic                          inv_en,
  input  logic [IDX_W-1:0]              inv_idx,
  output logic [LINES-1:0]              valid_vec,
  output logic [LINES-1:0][TAG_W-1:0]   tag_arr,
  output logic [LINES-1:0][DATA_W-1:0]  data_arr
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        tag_arr[g]   <= '0;
        data_arr[g]  <= '0;
      end else begin
        if (inv_en && inv_idx == MY_IDX)
          valid_vec[g] <= 1'b0;
        else if (fill_en && fill_idx == MY_IDX)
          valid_vec[g] <= 1'b1;
        if (fill_en && fill_idx == MY_IDX) begin
          tag_arr[g]  <= fill_tag;
          data_arr[g] <= fill_data;
        end else if (upd_en && upd_idx == MY_IDX) begin
          data_arr[g] <= upd_data;
        end
      end
    end
  end
endmodule

// File: rtl/wtsc_snoop_filter.sv
`timescale 1ns/1ps
module wtsc_snoop_filter #(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int ID_W   = 2
) (
  input  logic                        snp_valid,
  input  logic                        snp_we,
  input  logic [ID_W-1:0]             snp_src,
  input  logic [ID_W-1:0]             my_id,
  input  logic [ADDR_W-1:0]           snp_addr,
  input  logic [LINES-1:0]            valid_vec,
  input  logic [LINES-1:0][TAG_W-1:0] tag_arr,
  input  logic                        cpu_valid,
  input  logic [IDX_W-1:0]            cpu_idx,
  output logic                        kill,
  output logic [IDX_W-1:0]            kill_idx,
  output logic                        stall
);
  logic [TAG_W-1:0] snp_tag;
  logic             foreign_wr;

  assign kill_idx   = snp_addr[IDX_W-1:0];
  assign snp_tag    = snp_addr[ADDR_W-1:IDX_W];
  assign foreign_wr = snp_valid && snp_we && (snp_src != my_id);
  assign kill       = foreign_wr && valid_vec[kill_idx] && (tag_arr[kill_idx] == snp_tag);
  assign stall      = kill && cpu_valid && (cpu_idx == kill_idx);
endmodule

// File: rtl/wtsc_req_ctrl.sv
`timescale 1ns/1ps
module wtsc_req_ctrl
  import wtsc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cpu_valid,
  input  logic    cpu_we,
  input  logic    hit,
  input  logic    stall,
  input  logic    bus_gnt,
  output logic    bus_req,
  output bus_op_e bus_op,
  output logic    cpu_ready,
  output logic    fill_en,
  output logic    upd_en
);
  logic need_bus;
  logic granted;

  assign need_bus  = cpu_we || !hit;
  assign bus_req   = cpu_valid && !stall && need_bus;
  assign bus_op    = cpu_we ? OP_WRITE : OP_READ;
  assign granted   = bus_req && bus_gnt;
  assign cpu_ready = granted || (cpu_valid && !stall && !need_bus);
  assign fill_en   = granted && !cpu_we;
  assign upd_en    = granted && cpu_we && hit;

  AST_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_we && hit && !stall) |-> (cpu_ready && !bus_req)); // R3
  AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!cpu_ready && !bus_req)); // R10
  AST_MISS_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |-> !cpu_ready); // R2
endmodule

// File: rtl/wt_snoop_ctrl.sv
`timescale 1ns/1ps
module wt_snoop_ctrl
  import wtsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   my_id,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0]             valid_vec;
  logic [LINES-1:0][TAG_W-1:0]  tag_arr;
  logic [LINES-1:0][DATA_W-1:0] data_arr;
  logic [IDX_W-1:0]             cpu_idx;
  logic [TAG_W-1:0]             cpu_tag;
  logic                         hit;
  logic                         kill;
  logic [IDX_W-1:0]             kill_idx;
  logic                         stall;
  logic                         fill_en;
  logic                         upd_en;
  bus_op_e                      bus_op;

  assign cpu_idx   = cpu_addr[IDX_W-1:0];
  assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
  assign hit       = valid_vec[cpu_idx] && (tag_arr[cpu_idx] == cpu_tag);
  assign cpu_rdata = hit ? data_arr[cpu_idx] : bus_rdata;
  assign bus_we    = (bus_op == OP_WRITE);
  assign bus_addr  = cpu_addr;
  assign bus_wdata = cpu_wdata;

  wtsc_line_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_idx(cpu_idx), .fill_tag(cpu_tag), .fill_data(bus_rdata),
    .upd_en(upd_en), .upd_idx(cpu_idx), .upd_data(cpu_wdata),
    .inv_en(kill), .inv_idx(kill_idx),
    .valid_vec(valid_vec), .tag_arr(tag_arr), .data_arr(data_arr)
  );

  wtsc_snoop_filter #(.LINES(LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ID_W(ID_W)) u_snoop (
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_src(snp_src), .my_id(my_id),
    .snp_addr(snp_addr), .valid_vec(valid_vec), .tag_arr(tag_arr),
    .cpu_valid(cpu_valid), .cpu_idx(cpu_idx),
    .kill(kill), .kill_idx(kill_idx), .stall(stall)
  );

  wtsc_req_ctrl u_req (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .hit(hit), .stall(stall), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .bus_op(bus_op), .cpu_ready(cpu_ready),
    .fill_en(fill_en), .upd_en(upd_en)
  );

  AST_FILL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_vec[$past(cpu_idx)] && tag_arr[$past(cpu_idx)] == $past(cpu_tag))); // R2
  AST_KILL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !valid_vec[$past(kill_idx)]); // R6
  AST_WRITE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we && !kill) |=> (valid_vec == $past(valid_vec))); // R4
  AST_OWN_SNOOP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_src == my_id && !fill_en) |=> (valid_vec == $past(valid_vec))); // R8
  AST_READ_SNOOP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_we && !fill_en) |=> (valid_vec == $past(valid_vec))); // R9
  AST_WRITE_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (data_arr[$past(cpu_idx)] == $past(cpu_wdata))); // R5
endmodule

// File: tb/test_wt_snoop_ctrl.sv
`timescale 1ns/1ps
module test_wt_snoop_ctrl;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int NVEC   = 12;
  localparam logic [1:0] ME    = 2'd1;
  localparam logic [1:0] OTHER = 2'd3;

  // {we, exp_bus, dly[1:0], req[3:0], addr[7:0], wdata[15:0]}
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    32'h5210_0000,  // R2 read miss 0x10
    32'h0310_0000,  // R3 read hit 0x10
    32'hC410_1234,  // R4 write to held line
    32'h0510_0000,  // R5 read hit sees new word
    32'hE421_5555,  // R4 write to absent line
    32'h4421_0000,  // R4 still a miss
    32'h5C22_0000,  // R12 miss index 2
    32'h0C21_0000,  // R12 hit index 1
    32'h0C22_0000,  // R12 hit index 2
    32'h7B31_0000,  // R11 evicts 0x21
    32'h4B21_0000,  // R11 0x21 misses
    32'h4B31_0000   // R11 0x31 misses
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] my_id = ME;
  logic cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DATA_W-1:0] cpu_rdata;
  logic bus_req, bus_we;
  logic bus_gnt = 1'b0;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic snp_valid = 1'b0, snp_we = 1'b0;
  logic [1:0] snp_src = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic [DATA_W-1:0] mem [0:255];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;
  assign bus_rdata = mem[bus_addr];

  wt_snoop_ctrl i_wt_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .my_id(my_id),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_src(snp_src), .snp_addr(snp_addr)
  );

  task automatic check(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run_req(input logic we, input logic [7:0] addr, input logic [15:0] wdata,
                         input logic exp_bus, input int dly, input string rq);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata; bus_gnt = 1'b0;
    #1;
    check(bus_req == exp_bus, rq, 32'(bus_req), 32'(exp_bus));
    if (bus_req) begin
      check(bus_we == we && bus_addr == addr, rq, {23'd0, bus_we, bus_addr}, {23'd0, we, addr});
      for (int i = 0; i < dly; i++) begin
        check(cpu_ready == 1'b0, rq, 32'(cpu_ready), 32'd0);
        @(negedge clk); #1;
      end
      bus_gnt = 1'b1; #1;
      check(cpu_ready == 1'b1, rq, 32'(cpu_ready), 32'd1);
      if (we) check(bus_wdata == wdata, rq, 32'(bus_wdata), 32'(wdata));
      else    check(cpu_rdata == mem[addr], rq, 32'(cpu_rdata), 32'(mem[addr]));
      @(posedge clk);
      if (we) mem[addr] = wdata;
    end else begin
      check(cpu_ready == 1'b1, rq, 32'(cpu_ready), 32'd1);
      if (!we) check(cpu_rdata == mem[addr], rq, 32'(cpu_rdata), 32'(mem[addr]));
      @(posedge clk);
    end
    #1; cpu_valid = 1'b0; bus_gnt = 1'b0;
  endtask

  task automatic snoop(input logic we, input logic [1:0] src, input logic [7:0] addr, input logic [15:0] data);
    @(negedge clk);
    snp_valid = 1'b1; snp_we = we; snp_src = src; snp_addr = addr;
    if (we && src != ME) mem[addr] = data;
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 16'hA500 ^ 16'(a * 37);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(cpu_ready == 1'b0 && bus_req == 1'b0, "R1 idle after reset", {30'd0, cpu_ready, bus_req}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      run_req(VEC[v][31], VEC[v][23:16], VEC[v][15:0], VEC[v][30], int'(VEC[v][29:28]),
              $sformatf("R%0d vec%0d", VEC[v][27:24], v));
    end

    snoop(1'b1, ME, 8'h10, 16'h0000);         // R8 own write ignored
    run_req(1'b0, 8'h10, 16'h0, 1'b0, 0, "R8 own snoop keeps line");
    snoop(1'b0, OTHER, 8'h10, 16'h0000);      // R9 foreign read ignored
    run_req(1'b0, 8'h10, 16'h0, 1'b0, 0, "R9 read snoop keeps line");
    snoop(1'b1, OTHER, 8'h14, 16'h7777);      // R7 same index, other tag
    run_req(1'b0, 8'h10, 16'h0, 1'b0, 0, "R7 tag mismatch keeps line");
    snoop(1'b1, OTHER, 8'h10, 16'h4321);      // R6 full match drops line
    run_req(1'b0, 8'h10, 16'h0, 1'b1, 1, "R6 dropped line misses");
    run_req(1'b0, 8'h10, 16'h0, 1'b0, 0, "R6 refilled line hits");

    // R10 snoop collides with a pending read of the same line
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h10;
    snp_valid = 1'b1; snp_we = 1'b1; snp_src = OTHER; snp_addr = 8'h10;
    mem[8'h10] = 16'hBEEF;
    #1;
    check(cpu_ready == 1'b0 && bus_req == 1'b0, "R10 snoop wins", {30'd0, cpu_ready, bus_req}, 32'd0);
    @(posedge clk); #1;
    snp_valid = 1'b0;
    @(negedge clk); #1;
    check(bus_req == 1'b1, "R10 served as miss", 32'(bus_req), 32'd1);
    bus_gnt = 1'b1; #1;
    check(cpu_ready == 1'b1 && cpu_rdata == 16'hBEEF, "R10 fresh data", {15'd0, cpu_ready, cpu_rdata}, {15'd0, 1'b1, 16'hBEEF});
    @(posedge clk); #1;
    cpu_valid = 1'b0; bus_gnt = 1'b0;

    // R1 reset in mid-run clears every line
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    check(cpu_ready == 1'b0 && bus_req == 1'b0, "R1 idle after second reset", {30'd0, cpu_ready, bus_req}, 32'd0);
    run_req(1'b0, 8'h22, 16'h0, 1'b1, 0, "R1 held line lost on reset");
    run_req(1'b0, 8'h10, 16'h0, 1'b1, 2, "R1 held line lost on reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule